// File: doc/BRIEF.md
# Grouped Secure Interrupt Controller

This block combines a small interrupt distributor with one processor-facing interface. Each interrupt line carries four pieces of state: a pending bit, an enable bit, a priority, and a group bit. Group 0 holds the secure interrupts and group 1 holds the non-secure ones. Every cycle the block finds the best pending candidate. It forwards that candidate on either a normal interrupt output or a fast interrupt output. The choice depends on the candidate's group and on a fast-interrupt enable bit.

Software reaches the block through a plain register port with a valid/write/address/data handshake. Each access carries a secure flag. Read data is combinational and is valid in the same cycle as the request. All side effects take place at the clock edge that ends the request. An acknowledge read claims the winning interrupt, and a completion write retires it. Whether each of these is allowed depends on the security of the access and on an ack-control bit. Non-secure accesses see restricted, aliased views of the control, group, priority and running-priority state.

Top module: `gicIntCtl`

## Requirements
- R1: After reset, both interrupt outputs are low. A secure read of the running priority (address 0x05) returns 0xFF. The distributor control (0x00) reads 0. An acknowledge read (0x03) returns 1023.
- R2: A candidate is pending, enabled, and in a group enabled in distributor control. Among candidates, the lowest numeric priority wins. At equal priority, group 0 beats group 1. Remaining ties go to the lower interrupt ID.
- R3: The winner is forwarded only when three conditions hold. Its priority must be strictly below the priority mask (0x02, reset 0). It must be strictly below the running priority. Its group must be enabled in CPU control (0x01: bit0 group 0, bit1 group 1).
- R4: A forwarded group 0 winner drives fiqOut when CPU control bit3 is set; otherwise it drives irqOut. A group 1 winner always drives irqOut. The two outputs are never high together.
- R5: A non-secure acknowledge is refused when the winner is group 0. A refused acknowledge returns 1023 and leaves pending and active state unchanged.
- R6: A secure acknowledge of a group 1 winner succeeds only when CPU control bit2 (ack-control) is set. Otherwise it returns 1023.
- R7: A successful acknowledge does four things. It returns the interrupt ID. It clears the interrupt's pending bit. It sets its active bit (readable at 0x09). It loads the running priority with that interrupt's priority.
- R8: A completion write to 0x04 with an active ID clears that active bit and returns the running priority to 0xFF. A non-secure completion of a group 0 interrupt is ignored.
- R9: Distributor control and CPU control are banked. A secure access sees all bits. A non-secure access sees only bit0, which aliases the stored group 1 enable at bit1. Non-secure writes change only that stored bit.
- R10: Priority registers sit at 0x20+ID. Non-secure reads follow these rules:
  - a group 0 priority reads 0;
  - a group 1 priority reads shifted left by one;
  - the running priority reads 0 when its top bit is clear, else shifted left by one.
  A non-secure priority write to a group 1 interrupt stores {1, data[7:1]}. The same write to a group 0 interrupt is ignored.
- R11: The group register (0x06, 1 = group 1) reads 0 to a non-secure access and ignores non-secure writes. Non-secure writes to the enable register (0x08) and to the write-one-to-set pending register (0x07) affect only group 1 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Register access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSecure | input | 1 | Access carries the secure attribute |
| reqAddr | input | 6 | Register address |
| reqWdata | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, valid during a read request |
| irqOut | output | 1 | Normal interrupt request |
| fiqOut | output | 1 | Fast interrupt request |

## Verification
Read data and acknowledge results are due in the same cycle as the request. The bench therefore samples rdData shortly after driving a request, before the closing clock edge. State changes from a write or an acknowledge, and the resulting irqOut and fiqOut levels, are due one edge later. The bench checks them at the next falling edge or through a later read. Refused acknowledges and ignored writes are confirmed by reading back pending, active, group, enable and priority state before the next stimulus.

// File: rtl/gicPkg.sv
package gicPkg;
  localparam int ADDR_W = 6;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

  localparam logic [ADDR_W-1:0] A_DCTL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_CCTL   = 6'h01;
  localparam logic [ADDR_W-1:0] A_PMASK  = 6'h02;
  localparam logic [ADDR_W-1:0] A_ACK    = 6'h03;
  localparam logic [ADDR_W-1:0] A_EOI    = 6'h04;
  localparam logic [ADDR_W-1:0] A_RUNPRI = 6'h05;
  localparam logic [ADDR_W-1:0] A_GROUP  = 6'h06;
  localparam logic [ADDR_W-1:0] A_PEND   = 6'h07;
  localparam logic [ADDR_W-1:0] A_ENABLE = 6'h08;
  localparam logic [ADDR_W-1:0] A_ACTIVE = 6'h09;
  localparam logic [ADDR_W-1:0] A_PRIO   = 6'h20;

  typedef struct packed {
    logic secure;
    logic wrDctl;
    logic wrCctl;
    logic wrMask;
    logic wrGroup;
    logic wrPend;
    logic wrEnable;
    logic wrPrio;
    logic ackTake;
    logic eoiTake;
  } strobeT;
endpackage

// File: rtl/gicCtrl.sv
module gicCtrl
  import gicPkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic               reqSecure,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic               winValid,
  input  logic [IDX_W-1:0]   winId,
  input  logic               winGroup,
  input  logic [NUM_IRQ-1:0] groupVec,
  input  logic [NUM_IRQ-1:0] activeVec,
  input  logic               ackCtl,
  output strobeT             strobe,
  output logic [ID_W-1:0]    ackId
);
  logic rdReq, wrReq, ackAllowed, eoiOk;

  always_comb begin
    rdReq = reqValid && !reqWrite;
    wrReq = reqValid && reqWrite;
    // secure side owns group 0; group 1 needs ack-control when claimed securely
    ackAllowed = winValid && (winGroup ? (!reqSecure || ackCtl) : reqSecure);
    eoiOk = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (reqWdata == DATA_W'(i)) eoiOk = activeVec[i] && (groupVec[i] || reqSecure);
    end
    strobe          = '0;
    strobe.secure   = reqSecure;
    strobe.wrDctl   = wrReq && (reqAddr == A_DCTL);
    strobe.wrCctl   = wrReq && (reqAddr == A_CCTL);
    strobe.wrMask   = wrReq && (reqAddr == A_PMASK);
    strobe.wrGroup  = wrReq && (reqAddr == A_GROUP) && reqSecure;
    strobe.wrPend   = wrReq && (reqAddr == A_PEND);
    strobe.wrEnable = wrReq && (reqAddr == A_ENABLE);
    strobe.wrPrio   = wrReq && reqAddr[ADDR_W-1];
    strobe.ackTake  = rdReq && (reqAddr == A_ACK) && ackAllowed;
    strobe.eoiTake  = wrReq && (reqAddr == A_EOI) && eoiOk;
    ackId = strobe.ackTake ? ID_W'(winId) : SPURIOUS_ID;
  end
endmodule

// File: rtl/gicData.sv
module gicData
  import gicPkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobeT             strobe,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [DATA_W-1:0]  reqWdata,
  input  logic [ID_W-1:0]    ackId,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqOut,
  output logic               fiqOut,
  output logic               winValid,
  output logic [IDX_W-1:0]   winId,
  output logic               winGroup,
  output logic [PRIO_W-1:0]  winPrio,
  output logic [PRIO_W-1:0]  runPrio,
  output logic [PRIO_W-1:0]  pmask,
  output logic               fiqEnable,
  output logic               ackCtl,
  output logic [NUM_IRQ-1:0] groupVec,
  output logic [NUM_IRQ-1:0] pendVec,
  output logic [NUM_IRQ-1:0] activeVec
);
  logic [1:0]         dctl;
  logic [3:0]         cctl;
  logic [NUM_IRQ-1:0] enVec;
  logic [PRIO_W-1:0]  prio [NUM_IRQ];
  logic               found, cand;
  logic [NUM_IRQ-1:0] nsWritable;
  logic               unusedWdata;

  assign unusedWdata = ^reqWdata;
  assign fiqEnable   = cctl[3];
  assign ackCtl      = cctl[2];
  assign nsWritable  = strobe.secure ? '1 : groupVec;

  // winner search: {priority, group} ascending, lower ID keeps ties
  always_comb begin
    found = 1'b0;
    winId = '0;
    winPrio = '1;
    winGroup = 1'b1;
    for (int i = 0; i < NUM_IRQ; i++) begin
      cand = pendVec[i] && enVec[i] && (groupVec[i] ? dctl[1] : dctl[0]);
      if (cand && (!found || ({prio[i], groupVec[i]} < {winPrio, winGroup}))) begin
        found = 1'b1;
        winId = IDX_W'(i);
        winPrio = prio[i];
        winGroup = groupVec[i];
      end
    end
    winValid = found && (winPrio < pmask) && (winPrio < runPrio)
               && (winGroup ? cctl[1] : cctl[0]);
    fiqOut = winValid && !winGroup && cctl[3];
    irqOut = winValid && !fiqOut;
  end

  always_comb begin
    rdData = '0;
    if (reqValid && !reqWrite) begin
      case (reqAddr)
        A_DCTL:   rdData = strobe.secure ? DATA_W'(dctl) : DATA_W'(dctl[1]);
        A_CCTL:   rdData = strobe.secure ? DATA_W'(cctl) : DATA_W'(cctl[1]);
        A_PMASK:  rdData = DATA_W'(pmask);
        A_ACK:    rdData = DATA_W'(ackId);
        A_RUNPRI: rdData = strobe.secure ? DATA_W'(runPrio) :
                           (runPrio[PRIO_W-1] ? DATA_W'({runPrio[PRIO_W-2:0], 1'b0}) : '0);
        A_GROUP:  rdData = strobe.secure ? DATA_W'(groupVec) : '0;
        A_PEND:   rdData = DATA_W'(pendVec);
        A_ENABLE: rdData = DATA_W'(enVec);
        A_ACTIVE: rdData = DATA_W'(activeVec);
        default: begin
          for (int i = 0; i < NUM_IRQ; i++) begin
            if (reqAddr == A_PRIO + ADDR_W'(i)) begin
              if (strobe.secure) rdData = DATA_W'(prio[i]);
              else if (groupVec[i]) rdData = DATA_W'({prio[i][PRIO_W-2:0], 1'b0});
            end
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dctl <= '0;
      cctl <= '0;
      pmask <= '0;
      runPrio <= '1;
      groupVec <= '0;
      pendVec <= '0;
      enVec <= '0;
      activeVec <= '0;
      for (int i = 0; i < NUM_IRQ; i++) prio[i] <= '0;
    end else begin
      if (strobe.wrDctl) begin
        if (strobe.secure) dctl <= reqWdata[1:0];
        else dctl[1] <= reqWdata[0];
      end
      if (strobe.wrCctl) begin
        if (strobe.secure) cctl <= reqWdata[3:0];
        else cctl[1] <= reqWdata[0];
      end
      if (strobe.wrMask) pmask <= reqWdata[PRIO_W-1:0];
      if (strobe.wrGroup) groupVec <= reqWdata[NUM_IRQ-1:0];
      if (strobe.wrPend) pendVec <= pendVec | (reqWdata[NUM_IRQ-1:0] & nsWritable);
      if (strobe.wrEnable)
        enVec <= (enVec & ~nsWritable) | (reqWdata[NUM_IRQ-1:0] & nsWritable);
      for (int i = 0; i < NUM_IRQ; i++) begin
        if (strobe.wrPrio && (reqAddr == A_PRIO + ADDR_W'(i))) begin
          if (strobe.secure) prio[i] <= reqWdata[PRIO_W-1:0];
          else if (groupVec[i]) prio[i] <= {1'b1, reqWdata[PRIO_W-1:1]};
        end
        if (strobe.ackTake && (winId == IDX_W'(i))) begin
          pendVec[i] <= 1'b0;
          activeVec[i] <= 1'b1;
          runPrio <= prio[i];
        end
        if (strobe.eoiTake && (reqWdata == DATA_W'(i))) begin
          activeVec[i] <= 1'b0;
          runPrio <= '1;
        end
      end
    end
  end
endmodule

// File: rtl/gicIntCtl.sv
module gicIntCtl
  import gicPkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(NUM_IRQ)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              reqSecure,
  input  logic [5:0]        reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output logic              fiqOut
);
  strobeT             strobe;
  logic [ID_W-1:0]    ackId;
  logic               winValid, winGroup, fiqEnable, ackCtl;
  logic [IDX_W-1:0]   winId;
  logic [PRIO_W-1:0]  winPrio, runPrio, pmask;
  logic [NUM_IRQ-1:0] groupVec, pendVec, activeVec;

  gicCtrl #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) i_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqSecure(reqSecure),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .winValid(winValid),
    .winId(winId), .winGroup(winGroup), .groupVec(groupVec),
    .activeVec(activeVec), .ackCtl(ackCtl), .strobe(strobe), .ackId(ackId)
  );

  gicData #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) i_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqValid(reqValid),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .ackId(ackId), .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut),
    .winValid(winValid), .winId(winId), .winGroup(winGroup),
    .winPrio(winPrio), .runPrio(runPrio), .pmask(pmask),
    .fiqEnable(fiqEnable), .ackCtl(ackCtl), .groupVec(groupVec),
    .pendVec(pendVec), .activeVec(activeVec)
  );
endmodule

// File: rtl/gicIntCtlChecker.sv
module gicIntCtlChecker #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W = 8,
  parameter int DATA_W = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               reqValid,
  input logic               reqWrite,
  input logic               reqSecure,
  input logic [5:0]         reqAddr,
  input logic [DATA_W-1:0]  rdData,
  input logic               irqOut,
  input logic               fiqOut,
  input logic               winGroup,
  input logic [PRIO_W-1:0]  winPrio,
  input logic [PRIO_W-1:0]  runPrio,
  input logic [PRIO_W-1:0]  pmask,
  input logic               fiqEnable,
  input logic [NUM_IRQ-1:0] pendVec,
  input logic [NUM_IRQ-1:0] activeVec
);
  logic ackRead;
  assign ackRead = reqValid && !reqWrite && (reqAddr == 6'h03);

  p_out_exclusive_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(irqOut && fiqOut));

  p_fiq_group0_r4: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> (!winGroup && fiqEnable));

  p_forward_window_r3: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut || fiqOut) |-> ((winPrio < pmask) && (winPrio < runPrio)));

  p_ns_ack_group0_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && !reqSecure && !winGroup) |-> (rdData == DATA_W'(1023)));

  p_blocked_ack_stable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && (rdData == DATA_W'(1023))) |=> ($stable(pendVec) && $stable(activeVec)));

  p_ack_claims_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && (rdData != DATA_W'(1023))) |=> ((activeVec != '0) && (runPrio != '1)));
endmodule

bind gicIntCtl gicIntCtlChecker #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W), .DATA_W(DATA_W)) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqSecure(reqSecure), .reqAddr(reqAddr), .rdData(rdData),
  .irqOut(irqOut), .fiqOut(fiqOut), .winGroup(winGroup), .winPrio(winPrio),
  .runPrio(runPrio), .pmask(pmask), .fiqEnable(fiqEnable),
  .pendVec(pendVec), .activeVec(activeVec)
);

// File: tb/test_gicIntCtl.sv
module test_gicIntCtl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqSecure = 1'b0;
  logic [5:0]  reqAddr = '0;
  logic [31:0] reqWdata = '0;
  logic [31:0] rdData;
  logic        irqOut, fiqOut;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  gicIntCtl i_gicIntCtl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSecure(reqSecure), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdData(rdData), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  // {req[75:72], write, secure, addr[69:64], wdata[63:32], expected[31:0]}
  localparam int NV = 30;
  localparam logic [75:0] VEC [NV] = '{
    {4'd9,  1'b1, 1'b1, 6'h00, 32'h03, 32'h0},   // R9 enable both groups
    {4'd9,  1'b1, 1'b1, 6'h01, 32'h0F, 32'h0},   // R9 cpu ctl all bits
    {4'd3,  1'b1, 1'b1, 6'h02, 32'hF0, 32'h0},   // R3 mask
    {4'd11, 1'b1, 1'b1, 6'h06, 32'hF0, 32'h0},   // R11 groups
    {4'd10, 1'b1, 1'b1, 6'h22, 32'h40, 32'h0},   // R10
    {4'd10, 1'b1, 1'b1, 6'h25, 32'h40, 32'h0},   // R10
    {4'd10, 1'b1, 1'b1, 6'h26, 32'h30, 32'h0},   // R10
    {4'd11, 1'b1, 1'b1, 6'h08, 32'hFF, 32'h0},   // R11
    {4'd11, 1'b0, 1'b1, 6'h06, 32'h0,  32'hF0},  // R11
    {4'd11, 1'b0, 1'b0, 6'h06, 32'h0,  32'h00},  // R11 ns group read
    {4'd10, 1'b0, 1'b0, 6'h25, 32'h0,  32'h80},  // R10 ns view group1
    {4'd10, 1'b0, 1'b0, 6'h22, 32'h0,  32'h00},  // R10 ns view group0
    {4'd10, 1'b1, 1'b0, 6'h25, 32'h60, 32'h0},   // R10 ns write
    {4'd10, 1'b0, 1'b1, 6'h25, 32'h0,  32'hB0},  // R10
    {4'd10, 1'b1, 1'b0, 6'h22, 32'h10, 32'h0},   // R10 ignored
    {4'd10, 1'b0, 1'b1, 6'h22, 32'h0,  32'h40},  // R10
    {4'd10, 1'b1, 1'b1, 6'h25, 32'h40, 32'h0},   // R10 restore
    {4'd9,  1'b0, 1'b0, 6'h00, 32'h0,  32'h01},  // R9 alias
    {4'd9,  1'b0, 1'b1, 6'h00, 32'h0,  32'h03},  // R9
    {4'd9,  1'b0, 1'b0, 6'h01, 32'h0,  32'h01},  // R9 cpu alias
    {4'd9,  1'b1, 1'b0, 6'h00, 32'h0,  32'h0},   // R9 ns clears grp1
    {4'd9,  1'b0, 1'b1, 6'h00, 32'h0,  32'h01},  // R9
    {4'd9,  1'b1, 1'b1, 6'h00, 32'h03, 32'h0},   // R9 restore
    {4'd11, 1'b1, 1'b0, 6'h08, 32'h00, 32'h0},   // R11
    {4'd11, 1'b0, 1'b1, 6'h08, 32'h0,  32'h0F},  // R11
    {4'd11, 1'b1, 1'b1, 6'h08, 32'hFF, 32'h0},   // R11 restore
    {4'd11, 1'b1, 1'b0, 6'h06, 32'h0F, 32'h0},   // R11 ignored
    {4'd11, 1'b0, 1'b1, 6'h06, 32'h0,  32'hF0},  // R11
    {4'd11, 1'b1, 1'b0, 6'h07, 32'h01, 32'h0},   // R11 ns pend group0
    {4'd11, 1'b0, 1'b1, 6'h07, 32'h0,  32'h00}   // R11
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic acc(input logic w, input logic s, input logic [5:0] a,
                     input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = w; reqSecure = s; reqAddr = a; reqWdata = d;
    #1 r = rdData;
    @(posedge clk);
    #1 reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic wr(input logic s, input logic [5:0] a, input logic [31:0] d);
    logic [31:0] r;
    acc(1'b1, s, a, d, r);
  endtask

  task automatic rdChk(input string tag, input logic s, input logic [5:0] a, input logic [31:0] exp);
    logic [31:0] r;
    acc(1'b0, s, a, 32'h0, r);
    check(tag, r, exp);
  endtask

  task automatic outs(input string tag, input logic expIrq, input logic expFiq);
    @(negedge clk);
    check({tag, " irq/fiq"}, {30'h0, irqOut, fiqOut}, {30'h0, expIrq, expFiq});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1 reset state
    outs("R1", 1'b0, 1'b0);
    rdChk("R1 runprio", 1'b1, 6'h05, 32'hFF);
    rdChk("R1 dctl", 1'b1, 6'h00, 32'h0);
    rdChk("R1 ack", 1'b1, 6'h03, 32'd1023);

    for (int k = 0; k < NV; k++) begin
      logic [31:0] r;
      acc(VEC[k][71], VEC[k][70], VEC[k][69:64], VEC[k][63:32], r);
      if (!VEC[k][71]) begin
        checks++;
        if (r !== VEC[k][31:0]) begin
          errors++;
          $display("FAIL R%0d table row %0d: actual 0x%0h expected 0x%0h",
                   VEC[k][75:72], k, r, VEC[k][31:0]);
        end
      end
    end

    wr(1'b1, 6'h07, 32'h24);             // irq2 grp0, irq5 grp1, both 0x40
    outs("R4 fiq for group0", 1'b0, 1'b1);
    rdChk("R5 ns ack refused", 1'b0, 6'h03, 32'd1023);
    rdChk("R5 pend kept", 1'b1, 6'h07, 32'h24);
    rdChk("R5 active kept", 1'b1, 6'h09, 32'h0);
    rdChk("R2 group0 wins tie", 1'b1, 6'h03, 32'd2);
    rdChk("R7 pend cleared", 1'b1, 6'h07, 32'h20);
    rdChk("R7 active set", 1'b1, 6'h09, 32'h04);
    rdChk("R7 runprio", 1'b1, 6'h05, 32'h40);
    outs("R3 not below runprio", 1'b0, 1'b0);
    wr(1'b1, 6'h07, 32'h40);             // irq6 grp1 prio 0x30
    outs("R4 irq for group1", 1'b1, 1'b0);
    rdChk("R10 ns runprio low", 1'b0, 6'h05, 32'h0);
    wr(1'b0, 6'h04, 32'd2);
    rdChk("R8 ns eoi group0 ignored", 1'b1, 6'h09, 32'h04);
    rdChk("R8 runprio kept", 1'b1, 6'h05, 32'h40);
    wr(1'b1, 6'h04, 32'd2);
    rdChk("R8 active cleared", 1'b1, 6'h09, 32'h0);
    rdChk("R8 runprio idle", 1'b1, 6'h05, 32'hFF);
    rdChk("R10 ns runprio idle", 1'b0, 6'h05, 32'hFE);
    wr(1'b1, 6'h01, 32'h0B);             // ack-control off
    rdChk("R6 secure ack group1 refused", 1'b1, 6'h03, 32'd1023);
    rdChk("R6 pend kept", 1'b1, 6'h07, 32'h60);
    rdChk("R7 ns ack group1", 1'b0, 6'h03, 32'd6);
    rdChk("R7 runprio 0x30", 1'b1, 6'h05, 32'h30);
    outs("R3 equal-or-above runprio", 1'b0, 1'b0);
    wr(1'b0, 6'h04, 32'd6);
    rdChk("R8 ns eoi group1", 1'b1, 6'h05, 32'hFF);
    outs("R3 forwarded after eoi", 1'b1, 1'b0);
    wr(1'b1, 6'h02, 32'h40);
    outs("R3 mask equal blocks", 1'b0, 1'b0);
    wr(1'b1, 6'h02, 32'h41);
    outs("R3 mask above passes", 1'b1, 1'b0);
    wr(1'b1, 6'h01, 32'h09);
    outs("R3 cpu group1 disabled", 1'b0, 1'b0);
    wr(1'b1, 6'h01, 32'h0F);
    wr(1'b1, 6'h24, 32'h40);
    wr(1'b1, 6'h07, 32'h10);
    rdChk("R2 lower id wins tie", 1'b1, 6'h03, 32'd4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule